// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transceiver

This block sends and receives asynchronous serial frames. Bytes are pushed into a 16-entry transmit queue, and a serializer sends each one with a start bit, eight data bits (least significant first), an optional parity bit and one or two stop bits. A deserializer rebuilds incoming frames and pushes 12-bit entries into a 16-entry receive queue. Each entry carries the byte and four error flags. Both queues can be cut down to a single holding register.

Bit timing comes from an oversampling tick that runs at sixteen times the bit rate. The tick period is an integer count of clocks, plus an extra clock inserted whenever a 6-bit fraction (in 64ths) carries out of its accumulator. Interrupt outputs compare the queue fill levels against a threshold chosen in eighths of the depth. The receiver rejects glitches on the start bit and reports line breaks. The transmitter can hold the line low to send a break.

Top module: `async_xcvr`

## Requirements
- R1: While reset is held, `txd` is high, both queues read empty, `rx_irq` is low and, in queue mode with threshold 1/2, `tx_irq` is high.
- R2: A frame is a low start bit, then 8 data bits LSB first, then a parity bit when `par_en` is set (even: the ones count of data plus parity is even; odd when `par_odd` is set), then one high stop bit, or two when `stop2` is set. A frame looped back to `rxd` yields the entry `{4'b0000, data}`.
- R3: Each bit lasts 16 ticks. A tick period is `baud_int` clocks plus one whenever the running sum of `baud_frac` passes 64. With `baud_int`=1 and `baud_frac`=0 a bit is 16 clocks; with `baud_int`=2 and `baud_frac`=32 a bit is exactly 40 clocks.
- R4: Receive entry layout: bit 11 overrun, bit 10 break, bit 9 parity error, bit 8 framing error, bits 7..0 data. Entries leave the queue in arrival order.
- R5: When the received parity bit disagrees with the selected parity, bit 9 of that entry is set.
- R6: A stop bit sampled low, in a frame that is not a break, sets bit 8 and keeps the received data.
- R7: A low pulse on `rxd` that is high again at the start bit's mid-point produces no entry. The next valid frame is received normally.
- R8: When the start, data, parity and first stop samples are all low, the entry is 0x500 (break and framing set, data zero). The receiver then waits for the line to go high before it looks for a new start bit.
- R9: While `brk_send` is high, `txd` is low from the next clock on. When `brk_send` is released, an idle transmitter returns `txd` high.
- R10: In queue mode each queue holds 16 entries. A frame that completes while the receive queue is full is discarded, and the next entry stored has bit 11 set.
- R11: With `fifo_en` low each queue holds one entry. A push into a full transmit holding register is ignored, and that byte is never sent.
- R12: `trig_sel` 0,1,2,3 and 4..7 give thresholds of 2, 4, 8, 12 and 14 entries. In queue mode `rx_irq` means receive count >= threshold and `tx_irq` means transmit count <= threshold. With queues off, `rx_irq` means not empty and `tx_irq` means empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_int | input | 16 | Integer part of tick period, in clocks |
| baud_frac | input | 6 | Fractional part of tick period, in 64ths |
| fifo_en | input | 1 | 1: 16-entry queues, 0: single holding registers |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when set, even otherwise |
| stop2 | input | 1 | Send two stop bits |
| brk_send | input | 1 | Force the line low (break) |
| trig_sel | input | 3 | Interrupt threshold select |
| tx_push | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_pop | input | 1 | Remove the head receive entry |
| rx_entry | output | 12 | Head receive entry (flags and data) |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_irq | output | 1 | Receive level interrupt |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
The bench measures the start-bit length with a half-integer divisor. A design that dropped the fractional carry, or applied it unevenly, would give 32 clocks instead of 40. It drives hand-built frames with a short start glitch, a bad parity bit, a low stop bit and a long low break. A receiver that sampled the start bit on its edge, raised parity on the wrong sense, or produced a string of break entries during one long low would each leave an extra or wrongly flagged entry in the scoreboard. It fills the receive queue past 16 entries and pushes into a full holding register, so an overrun flag placed on the wrong entry, or an ignored push that was stored anyway, shows up as a mismatch or as a stray frame.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int BYTE_W  = 8;
  localparam int FLAG_W  = 4;
  localparam int ENTRY_W = BYTE_W + FLAG_W;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rx_state_e;

  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              perr;
    logic              ferr;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/xcvr_baud.sv
module xcvr_baud #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  logic [INT_W-1:0]  cnt_q, cnt_d, base;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;

  always_comb begin
    base  = (div_int == '0) ? INT_W'(1) : div_int;
    sum   = {1'b0, acc_q} + {1'b0, div_frac};
    tick  = (cnt_q == '0);
    cnt_d = cnt_q - INT_W'(1);
    acc_d = acc_q;
    if (tick) begin
      acc_d = sum[FRAC_W-1:0];
      cnt_d = base - INT_W'(1) + INT_W'(sum[FRAC_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // Tick spacing is at least div_int clocks
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int > INT_W'(1)) |=> !tick);
endmodule

// File: rtl/xcvr_fifo.sv
module xcvr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, cap;
  logic          do_push, do_pop;

  always_comb begin
    cap     = fifo_en ? CW'(DEPTH) : CW'(1);
    full    = (cnt_q >= cap);
    empty   = (cnt_q == '0);
    do_push = push & ~full;
    do_pop  = pop & ~empty;
    wp_d    = wp_q + AW'(do_push);
    rp_d    = rp_q + AW'(do_pop);
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    rdata   = mem[rp_q];
    count   = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_push_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/xcvr_tx.sv
module xcvr_tx
  import xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop2,
  input  logic              brk,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              pop,
  output logic              txd
);
  tx_state_e         st_q, st_d;
  logic [3:0]        sub_q, sub_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              par_q, par_d, stp_q, stp_d, line, txd_q;

  always_comb begin
    st_d = st_q; sub_d = sub_q; bit_d = bit_q; sh_d = sh_q;
    par_d = par_q; stp_d = stp_q; pop = 1'b0;
    case (st_q)
      TX_START: line = 1'b0;
      TX_DATA:  line = sh_q[0];
      TX_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
    if (tick) begin
      if (st_q == TX_IDLE) begin
        if (!fifo_empty) begin
          pop   = 1'b1;
          st_d  = TX_START;
          sub_d = '0;
          sh_d  = fifo_data;
          par_d = (^fifo_data) ^ par_odd;
        end
      end else begin
        sub_d = sub_q + 4'd1;
        if (sub_q == 4'd15) begin
          case (st_q)
            TX_START: begin st_d = TX_DATA; bit_d = '0; end
            TX_DATA: begin
              sh_d  = sh_q >> 1;
              bit_d = bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                st_d  = par_en ? TX_PAR : TX_STOP;
                stp_d = 1'b0;
              end
            end
            TX_PAR: begin st_d = TX_STOP; stp_d = 1'b0; end
            TX_STOP: begin
              if (stop2 && !stp_q) stp_d = 1'b1;
              else                 st_d  = TX_IDLE;
            end
            default: st_d = TX_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; sub_q <= '0; bit_q <= '0; sh_q <= '0;
      par_q <= 1'b0; stp_q <= 1'b0; txd_q <= 1'b1;
    end else begin
      st_q <= st_d; sub_q <= sub_d; bit_q <= bit_d; sh_q <= sh_d;
      par_q <= par_d; stp_q <= stp_d; txd_q <= brk ? 1'b0 : line;
    end
  end

  assign txd = txd_q;

  assert_pop_starts_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (st_q == TX_START));
  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);
endmodule

// File: rtl/xcvr_rx.sv
module xcvr_rx
  import xcvr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxd,
  input  logic      par_en,
  input  logic      par_odd,
  input  logic      fifo_full,
  output logic      wr,
  output rx_entry_t entry
);
  rx_state_e         st_q, st_d;
  logic [3:0]        sub_q, sub_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              s1_q, s2_q, perr_q, perr_d, low_q, low_d, ovp_q, ovp_d;

  always_comb begin
    st_d = st_q; sub_d = sub_q; bit_d = bit_q; sh_d = sh_q;
    perr_d = perr_q; low_d = low_q; ovp_d = ovp_q;
    wr = 1'b0; entry = '0;
    case (st_q)
      RX_WAITHI: if (s2_q) st_d = RX_IDLE;
      RX_IDLE: if (tick && !s2_q) begin st_d = RX_START; sub_d = '0; end
      default: if (tick) begin
        sub_d = sub_q + 4'd1;
        case (st_q)
          RX_START: if (sub_q == 4'd7) begin
            if (s2_q) st_d = RX_IDLE;
            else begin
              st_d = RX_DATA; sub_d = '0; bit_d = '0; low_d = 1'b1; perr_d = 1'b0;
            end
          end
          RX_DATA: if (sub_q == 4'd15) begin
            sh_d  = {s2_q, sh_q[BYTE_W-1:1]};
            low_d = low_q & ~s2_q;
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) st_d = par_en ? RX_PAR : RX_STOP;
          end
          RX_PAR: if (sub_q == 4'd15) begin
            perr_d = s2_q ^ (^sh_q) ^ par_odd;
            low_d  = low_q & ~s2_q;
            st_d   = RX_STOP;
          end
          RX_STOP: if (sub_q == 4'd15) begin
            if (low_q && !s2_q) begin
              entry.brk = 1'b1; entry.ferr = 1'b1; st_d = RX_WAITHI;
            end else begin
              entry.data = sh_q; entry.perr = perr_q; entry.ferr = ~s2_q; st_d = RX_IDLE;
            end
            if (fifo_full) ovp_d = 1'b1;
            else begin
              wr = 1'b1; entry.ovr = ovp_q; ovp_d = 1'b0;
            end
          end
          default: st_d = RX_IDLE;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1; st_q <= RX_IDLE; sub_q <= '0; bit_q <= '0;
      sh_q <= '0; perr_q <= 1'b0; low_q <= 1'b0; ovp_q <= 1'b0;
    end else begin
      s1_q <= rxd; s2_q <= s1_q; st_q <= st_d; sub_q <= sub_d; bit_q <= bit_d;
      sh_q <= sh_d; perr_q <= perr_d; low_q <= low_d; ovp_q <= ovp_d;
    end
  end

  assert_break_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && entry.brk) |-> (entry.data == '0 && entry.ferr && !entry.perr));
  assert_false_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && tick && sub_q == 4'd7 && s2_q) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/async_xcvr.sv
module async_xcvr
  import xcvr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INT_W-1:0]   baud_int,
  input  logic [FRAC_W-1:0]  baud_frac,
  input  logic               fifo_en,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               stop2,
  input  logic               brk_send,
  input  logic [2:0]         trig_sel,
  input  logic               tx_push,
  input  logic [BYTE_W-1:0]  tx_data,
  output logic               tx_full,
  output logic               tx_empty,
  output logic               tx_irq,
  input  logic               rx_pop,
  output logic [ENTRY_W-1:0] rx_entry,
  output logic               rx_empty,
  output logic               rx_full,
  output logic               rx_irq,
  input  logic               rxd,
  output logic               txd
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]        rs_q;
  logic              rst_i, tick, tx_pop, rx_wr;
  logic [BYTE_W-1:0] tx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt, lvl;
  rx_entry_t         rx_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  xcvr_baud #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_baud (
    .clk(clk), .rst_n(rst_i), .div_int(baud_int), .div_frac(baud_frac), .tick(tick));

  xcvr_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i), .fifo_en(fifo_en), .push(tx_push), .wdata(tx_data),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  xcvr_tx u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .par_en(par_en), .par_odd(par_odd),
    .stop2(stop2), .brk(brk_send), .fifo_empty(tx_empty), .fifo_data(tx_head),
    .pop(tx_pop), .txd(txd));

  xcvr_rx u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .fifo_full(rx_full), .wr(rx_wr), .entry(rx_new));

  xcvr_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i), .fifo_en(fifo_en), .push(rx_wr), .wdata(rx_new),
    .pop(rx_pop), .rdata(rx_entry), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  always_comb begin
    case (trig_sel)
      3'd0:    lvl = CW'(DEPTH / 8);
      3'd1:    lvl = CW'(DEPTH / 4);
      3'd2:    lvl = CW'(DEPTH / 2);
      3'd3:    lvl = CW'(DEPTH * 3 / 4);
      default: lvl = CW'(DEPTH * 7 / 8);
    endcase
    tx_irq = fifo_en ? (tx_cnt <= lvl) : tx_empty;
    rx_irq = fifo_en ? (rx_cnt >= lvl) : ~rx_empty;
  end
endmodule

// File: tb/async_xcvr_test.sv
module async_xcvr_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [15:0] baud_int;
  logic [5:0]  baud_frac;
  logic        fifo_en, par_en, par_odd, stop2, brk_send;
  logic [2:0]  trig_sel;
  logic        tx_push;
  logic [7:0]  tx_data;
  logic        tx_full, tx_empty, tx_irq;
  logic        rx_pop = 1'b0;
  logic [11:0] rx_entry;
  logic        rx_empty, rx_full, rx_irq, rxd, txd;
  logic        loop, rxd_man, mon_hold;
  logic [11:0] exp_q [$];
  int          checks = 0, fails = 0;

  assign rxd = loop ? txd : rxd_man;

  async_xcvr uut (
    .clk(clk), .rst_n(rst_n), .baud_int(baud_int), .baud_frac(baud_frac),
    .fifo_en(fifo_en), .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
    .brk_send(brk_send), .trig_sel(trig_sel), .tx_push(tx_push), .tx_data(tx_data),
    .tx_full(tx_full), .tx_empty(tx_empty), .tx_irq(tx_irq), .rx_pop(rx_pop),
    .rx_entry(rx_entry), .rx_empty(rx_empty), .rx_full(rx_full), .rx_irq(rx_irq),
    .rxd(rxd), .txd(txd));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops each receive entry and compares with the scoreboard queue
  always @(negedge clk) begin
    if (rx_pop) rx_pop = 1'b0;
    else if (rst_n && !mon_hold && !rx_empty) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4: unexpected entry actual %0h expected none", rx_entry);
      end else begin
        check("R4 scoreboard entry", {20'd0, rx_entry}, {20'd0, exp_q.pop_front()});
      end
      rx_pop = 1'b1;
    end
  end

  task automatic send(input logic [7:0] d, input bit expect_it, input logic [11:0] e);
    while (tx_full) @(negedge clk);
    tx_data = d; tx_push = 1'b1;
    if (expect_it) exp_q.push_back(e);
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_idle(input int cyc);
    while (!tx_empty) @(negedge clk);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic rx_bit(input logic b);
    rxd_man = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit with_par, input logic pbit, input logic sbit);
    rx_bit(1'b0);
    for (int i = 0; i < 8; i++) rx_bit(d[i]);
    if (with_par) rx_bit(pbit);
    rx_bit(sbit);
    rxd_man = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic measure_start(output int n);
    n = 0;
    while (txd) @(negedge clk);
    while (!txd) begin n++; @(negedge clk); end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; baud_int = 16'd1; baud_frac = 6'd0; fifo_en = 1'b1;
    par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0; brk_send = 1'b0; trig_sel = 3'd2;
    tx_push = 1'b0; tx_data = 8'h00; loop = 1'b1; rxd_man = 1'b1; mon_hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 txd idle", txd, 1);
    check("R1 tx_empty", tx_empty, 1);
    check("R1 rx_empty", rx_empty, 1);
    check("R1 rx_irq", rx_irq, 0);
    check("R1 R12 tx_irq", tx_irq, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: 8N1 loopback
    send(8'h55, 1, 12'h055); send(8'hA3, 1, 12'h0A3);
    send(8'h00, 1, 12'h000); send(8'hFF, 1, 12'h0FF);
    wait_idle(260);
    // R2: even parity, two stop bits; then odd parity
    par_en = 1'b1; stop2 = 1'b1;
    send(8'h3C, 1, 12'h03C); send(8'h81, 1, 12'h081); send(8'h7E, 1, 12'h07E);
    wait_idle(260);
    par_odd = 1'b1;
    send(8'h01, 1, 12'h001); send(8'hC5, 1, 12'h0C5);
    wait_idle(260);
    par_en = 1'b0; par_odd = 1'b0; stop2 = 1'b0;

    // R3: start bit length, integer and fractional divisors
    send(8'hFF, 1, 12'h0FF);
    measure_start(n);
    check("R3 bit length int=1", n, 16);
    wait_idle(260);
    baud_int = 16'd2; baud_frac = 6'd32;
    send(8'hFF, 1, 12'h0FF);
    measure_start(n);
    check("R3 bit length int=2 frac=32", n, 40);
    wait_idle(700);
    baud_int = 16'd1; baud_frac = 6'd0;
    repeat (4) @(negedge clk);

    // R5: parity error, then valid parity
    loop = 1'b0; par_en = 1'b1;
    exp_q.push_back(12'h203); rx_frame(8'h03, 1, 1'b1, 1'b1);
    exp_q.push_back(12'h003); rx_frame(8'h03, 1, 1'b0, 1'b1);
    par_en = 1'b0;
    // R6: framing error
    exp_q.push_back(12'h141); rx_frame(8'h41, 0, 1'b0, 1'b0);
    // R7: short glitch on the start bit
    rxd_man = 1'b0; repeat (4) @(negedge clk);
    rxd_man = 1'b1; repeat (40) @(negedge clk);
    check("R7 glitch gives no entry", rx_empty, 1);
    check("R7 glitch scoreboard drained", exp_q.size(), 0);
    exp_q.push_back(12'h03C); rx_frame(8'h3C, 0, 1'b0, 1'b1);
    // R8: line break, then a normal frame
    exp_q.push_back(12'h500);
    rxd_man = 1'b0; repeat (16 * 12) @(negedge clk);
    rxd_man = 1'b1; repeat (40) @(negedge clk);
    check("R8 single break entry", exp_q.size(), 0);
    exp_q.push_back(12'h05A); rx_frame(8'h5A, 0, 1'b0, 1'b1);

    // R9: break transmission
    brk_send = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 txd low on break", txd, 0);
    repeat (50) @(negedge clk);
    check("R9 txd held low", txd, 0);
    brk_send = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 txd idle after break", txd, 1);
    loop = 1'b1;

    // R12: transmit threshold 2 entries
    trig_sel = 3'd0;
    send(8'h10, 1, 12'h010); send(8'h20, 1, 12'h020);
    send(8'h30, 1, 12'h030); send(8'h40, 1, 12'h040);
    check("R12 tx_irq above threshold", tx_irq, 0);
    wait_idle(260);
    check("R12 tx_irq at empty", tx_irq, 1);

    // R10 R12: receive thresholds and overrun
    mon_hold = 1'b1; trig_sel = 3'd1;
    for (int i = 0; i < 3; i++) send(8'hA0 + 8'(i), 1, 12'h0A0 + 12'(i));
    wait_idle(260);
    check("R12 rx_irq below 4", rx_irq, 0);
    send(8'hA3, 1, 12'h0A3);
    wait_idle(260);
    check("R12 rx_irq at 4", rx_irq, 1);
    trig_sel = 3'd4;
    @(negedge clk);
    check("R12 rx_irq below 14", rx_irq, 0);
    for (int i = 4; i < 14; i++) send(8'hA0 + 8'(i), 1, 12'h0A0 + 12'(i));
    wait_idle(260);
    check("R12 rx_irq at 14", rx_irq, 1);
    check("R10 not yet full", rx_full, 0);
    send(8'hAE, 1, 12'h0AE); send(8'hAF, 1, 12'h0AF);
    wait_idle(260);
    check("R10 full at 16", rx_full, 1);
    send(8'h99, 0, 12'h000);
    wait_idle(260);
    check("R10 still full after dropped frame", rx_full, 1);
    mon_hold = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    send(8'h66, 1, 12'h866);
    wait_idle(260);
    check("R10 overrun entry consumed", exp_q.size(), 0);

    // R11: single holding register
    fifo_en = 1'b0; trig_sel = 3'd2;
    send(8'h11, 1, 12'h011);
    repeat (4) @(negedge clk);
    check("R11 holding drained into shifter", tx_empty, 1);
    send(8'h22, 1, 12'h022);
    check("R11 holding full after one push", tx_full, 1);
    check("R12 tx_irq off when holding full", tx_irq, 0);
    tx_data = 8'h33; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
    check("R11 still full after ignored push", tx_full, 1);
    wait_idle(400);
    check("R11 ignored byte never sent", rx_empty, 1);
    check("R11 scoreboard drained", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule